// File: doc/BRIEF.md
# Two-Way Data Cache Array with Invalidation Port

This block is the storage and lookup core of a small on-chip data cache. It holds 64 sets of two ways. Each way keeps one 22-bit address tag, a 16-byte line of four 32-bit words, and one valid flag per word, so a line may be only partly filled. The processor side issues one lookup per cycle. The block compares the address against both ways of the indexed set and registers the hit flag, the hitting way and the read data for the following cycle. A store that hits updates the stored word in place (write-through). A store that misses leaves the array alone. A separate fill port writes one word at a time. The block chooses the way for the fill itself: it reuses a way that already holds the tag, otherwise it takes an empty way, and otherwise it takes the way named by a per-set least-recently-used bit.

An eight-signal external bus can knock out validity for one whole set (both ways) or for the entire array. The valid flags have an independent clear path. An invalidation therefore never stalls or reorders a lookup or a fill issued in the same cycle. A lookup always sees the array as it stood at the start of its cycle. Only when an invalidation and a fill land on the same set in the same cycle does the invalidation take precedence, which leaves the filled word invalid.

Address split: tag = addr[31:10], set = addr[9:4], word = addr[3:2]. Bits [1:0] are ignored.

Top module: `dc2_cache`

## Requirements
- R1: After reset every valid flag is clear, rsp_valid is low, and the first lookup of any address misses.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_hit, rsp_way and rsp_rdata belong to that request. rsp_rdata is 0 for misses and for stores.
- R3: A lookup hits only when a way of the indexed set holds the same tag and has the valid flag of the requested word set. Another word of a partly valid line, or a different tag, misses.
- R4: A word written through the fill port is returned by a load issued in the next cycle or later, with the filled data.
- R5: A store that hits replaces the stored word, and later loads return the new value. A store that misses allocates nothing.
- R6: A fill that matches no valid line goes to an empty way (way 0 before way 1). When both ways hold data it goes to the least recently used way. Every hit and every fill marks its way as most recently used.
- R7: A set invalidation clears all word flags in both ways of the addressed set, and leaves every other set unchanged.
- R8: A total invalidation clears every valid flag in the array, whatever the set field holds.
- R9: A lookup issued in the same cycle as an invalidation or a fill is answered from the array state before that cycle, with no stall.
- R10: When a fill and an invalidation address the same set in the same cycle, the filled word ends up invalid. A fill to a different set in that cycle is kept.
- R11: inv_bus[7] is the strobe, inv_bus[6] selects total (1) or single-set (0), and inv_bus[5:0] is the set. While the strobe is 0 the bus has no effect.
- R12: Filling a new tag into a way leaves only the filled word valid in that way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_write | input | 1 | Request is a store |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Store data |
| fill_valid | input | 1 | Fill word this cycle |
| fill_addr | input | 32 | Fill byte address |
| fill_data | input | 32 | Fill word |
| inv_bus | input | 8 | Strobe, total/set select, set index |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Previous request hit |
| rsp_way | output | 1 | Way that hit |
| rsp_rdata | output | 32 | Load data on a hit, else 0 |

## Verification
The assertions assume that a store hit and a fill never target the same word in the same cycle. They also assume that the same tag is never filled into both ways of a set at once. The stimulus respects both conditions by building every fill and store address from a fixed plan of tags and sets, and by checking the way choice as it goes. The property that checks fill-then-load takes it for granted that no store to the filled word occurs in the fill's cycle. The scripted sequence never pairs those two, and it places every same-cycle invalidation on either the same set or a different set from the fill on purpose.

// File: rtl/dc2_pkg.sv
package dc2_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        INV_IDLE     = 2'd0,
        INV_ONE_SET  = 2'd1,
        INV_ALL_SETS = 2'd2
    } inv_kind_e;
endpackage

// File: rtl/dc2_inv_decode.sv
module dc2_inv_decode #(
    parameter int SET_W = 6
) (
    input  logic [SET_W+1:0]    inv_bus,
    output dc2_pkg::inv_kind_e  kind,
    output logic [SET_W-1:0]    set_idx
);
    import dc2_pkg::*;

    always_comb begin
        set_idx = inv_bus[SET_W-1:0];
        unique case ({inv_bus[SET_W+1], inv_bus[SET_W]})
            2'b10:   kind = INV_ONE_SET;
            2'b11:   kind = INV_ALL_SETS;
            default: kind = INV_IDLE;
        endcase
    end
endmodule

// File: rtl/dc2_tag_valid.sv
module dc2_tag_valid #(
    parameter int SETS  = 64,
    parameter int TAG_W = 22,
    parameter int WORDS = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int WAYS   = dc2_pkg::WAYS
) (
    input  logic               clk,
    input  logic               rst_n,
    // lookup side
    input  logic [SET_W-1:0]   lk_set,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [WSEL_W-1:0]  lk_word,
    output logic [WAYS-1:0]    lk_hit_way,
    // fill side
    input  logic [SET_W-1:0]   fl_set,
    input  logic [TAG_W-1:0]   fl_tag,
    input  logic [WSEL_W-1:0]  fl_word,
    output logic [WAYS-1:0]    fl_match,
    output logic [WAYS-1:0]    fl_empty,
    input  logic               fl_en,
    input  logic               fl_way,
    input  logic               fl_new_tag,
    // invalidation side
    input  dc2_pkg::inv_kind_e inv_kind,
    input  logic [SET_W-1:0]   inv_set
);
    import dc2_pkg::*;

    logic [TAG_W-1:0] tag_q [WAYS][SETS];
    logic [WORDS-1:0] vld_q [WAYS][SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign lk_hit_way[w] = (tag_q[w][lk_set] == lk_tag) && vld_q[w][lk_set][lk_word];
        assign fl_empty[w]   = (vld_q[w][fl_set] == '0);
        assign fl_match[w]   = !fl_empty[w] && (tag_q[w][fl_set] == fl_tag);
    end

    always_ff @(posedge clk) begin
        if (fl_en && fl_new_tag) begin
            tag_q[fl_way][fl_set] <= fl_tag;
        end
    end

    // Fill sets flags first; the clear path is applied last so it wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    vld_q[w][s] <= '0;
                end
            end
        end else begin
            if (fl_en) begin
                if (fl_new_tag) begin
                    vld_q[fl_way][fl_set] <= {{(WORDS-1){1'b0}}, 1'b1} << fl_word;
                end else begin
                    vld_q[fl_way][fl_set][fl_word] <= 1'b1;
                end
            end
            unique case (inv_kind)
                INV_ONE_SET: begin
                    for (int w = 0; w < WAYS; w++) begin
                        vld_q[w][inv_set] <= '0;
                    end
                end
                INV_ALL_SETS: begin
                    for (int w = 0; w < WAYS; w++) begin
                        for (int s = 0; s < SETS; s++) begin
                            vld_q[w][s] <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dc2_data_array.sv
module dc2_data_array #(
    parameter int SETS   = 64,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int WAYS   = dc2_pkg::WAYS
) (
    input  logic                         clk,
    input  logic [SET_W-1:0]             rd_set,
    input  logic [WSEL_W-1:0]            rd_word,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                         st_en,
    input  logic                         st_way,
    input  logic [SET_W-1:0]             st_set,
    input  logic [WSEL_W-1:0]            st_word,
    input  logic [DATA_W-1:0]            st_data,
    input  logic                         fl_en,
    input  logic                         fl_way,
    input  logic [SET_W-1:0]             fl_set,
    input  logic [WSEL_W-1:0]            fl_word,
    input  logic [DATA_W-1:0]            fl_data
);
    logic [DATA_W-1:0] data_q [WAYS][SETS][WORDS];

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_data[w] = data_q[w][rd_set][rd_word];
    end

    always_ff @(posedge clk) begin
        if (st_en) begin
            data_q[st_way][st_set][st_word] <= st_data;
        end
        if (fl_en) begin
            data_q[fl_way][fl_set][fl_word] <= fl_data;
        end
    end
endmodule

// File: rtl/dc2_lru.sv
module dc2_lru #(
    parameter int SETS = 64,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] fl_set,
    output logic             fl_lru,
    input  logic             hit_en,
    input  logic [SET_W-1:0] hit_set,
    input  logic             hit_way,
    input  logic             fl_en,
    input  logic             fl_way
);
    logic [SETS-1:0] lru_q;

    assign fl_lru = lru_q[fl_set];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else begin
            if (hit_en) begin
                lru_q[hit_set] <= ~hit_way;
            end
            if (fl_en) begin
                lru_q[fl_set] <= ~fl_way;
            end
        end
    end
endmodule

// File: rtl/dc2_cache.sv
module dc2_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 64,
    parameter int WORDS  = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = WSEL_W + BYTE_W,
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
    localparam int INV_W  = SET_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [INV_W-1:0]  inv_bus,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_way,
    output logic [DATA_W-1:0] rsp_rdata
);
    import dc2_pkg::*;

    logic [TAG_W-1:0]  lk_tag, fl_tag;
    logic [SET_W-1:0]  lk_set, fl_set, inv_set;
    logic [WSEL_W-1:0] lk_word, fl_word;
    logic [WAYS-1:0]   lk_hit_way, fl_match, fl_empty;
    logic [WAYS-1:0][DATA_W-1:0] rd_data;
    inv_kind_e         inv_kind;
    logic              hit, hit_way, fl_lru, fl_way, fl_new_tag, st_en;
    logic              unused_lowbits;

    assign lk_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign lk_set  = req_addr[OFF_W +: SET_W];
    assign lk_word = req_addr[BYTE_W +: WSEL_W];
    assign fl_tag  = fill_addr[ADDR_W-1 -: TAG_W];
    assign fl_set  = fill_addr[OFF_W +: SET_W];
    assign fl_word = fill_addr[BYTE_W +: WSEL_W];
    assign unused_lowbits = ^{req_addr[BYTE_W-1:0], fill_addr[BYTE_W-1:0]};

    dc2_inv_decode #(.SET_W(SET_W)) u_inv (
        .inv_bus (inv_bus),
        .kind    (inv_kind),
        .set_idx (inv_set)
    );

    dc2_tag_valid #(.SETS(SETS), .TAG_W(TAG_W), .WORDS(WORDS)) u_tv (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_set     (lk_set),
        .lk_tag     (lk_tag),
        .lk_word    (lk_word),
        .lk_hit_way (lk_hit_way),
        .fl_set     (fl_set),
        .fl_tag     (fl_tag),
        .fl_word    (fl_word),
        .fl_match   (fl_match),
        .fl_empty   (fl_empty),
        .fl_en      (fill_valid),
        .fl_way     (fl_way),
        .fl_new_tag (fl_new_tag),
        .inv_kind   (inv_kind),
        .inv_set    (inv_set)
    );

    assign hit     = req_valid && (lk_hit_way != '0);
    assign hit_way = lk_hit_way[1];
    assign st_en   = hit && req_write;

    // Way choice for a fill: reuse matching line, then empty way, then LRU.
    always_comb begin
        if (fl_match[0]) begin
            fl_way = 1'b0; fl_new_tag = 1'b0;
        end else if (fl_match[1]) begin
            fl_way = 1'b1; fl_new_tag = 1'b0;
        end else if (fl_empty[0]) begin
            fl_way = 1'b0; fl_new_tag = 1'b1;
        end else if (fl_empty[1]) begin
            fl_way = 1'b1; fl_new_tag = 1'b1;
        end else begin
            fl_way = fl_lru; fl_new_tag = 1'b1;
        end
    end

    dc2_data_array #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .rd_set  (lk_set),
        .rd_word (lk_word),
        .rd_data (rd_data),
        .st_en   (st_en),
        .st_way  (hit_way),
        .st_set  (lk_set),
        .st_word (lk_word),
        .st_data (req_wdata),
        .fl_en   (fill_valid),
        .fl_way  (fl_way),
        .fl_set  (fl_set),
        .fl_word (fl_word),
        .fl_data (fill_data)
    );

    dc2_lru #(.SETS(SETS)) u_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .fl_set  (fl_set),
        .fl_lru  (fl_lru),
        .hit_en  (hit),
        .hit_set (lk_set),
        .hit_way (hit_way),
        .fl_en   (fill_valid),
        .fl_way  (fl_way)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= hit;
            rsp_way   <= hit && hit_way;
            rsp_rdata <= (hit && !req_write) ? rd_data[hit_way] : '0;
        end
    end
endmodule

// File: rtl/dc2_cache_chk.sv
module dc2_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 64,
    parameter int WORDS  = 4,
    localparam int SET_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int OFF_W  = WSEL_W + BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic [DATA_W-1:0] fill_data,
    input logic [SET_W+1:0]  inv_bus,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic              inv_d_stb, inv_d_all, fd_v;
    logic [SET_W-1:0]  inv_d_set;
    logic [ADDR_W-1:0] fd_addr;
    logic [DATA_W-1:0] fd_data;
    logic              fd_killed, inv_hits_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_d_stb <= 1'b0;
            inv_d_all <= 1'b0;
            inv_d_set <= '0;
            fd_v      <= 1'b0;
            fd_addr   <= '0;
            fd_data   <= '0;
        end else begin
            inv_d_stb <= inv_bus[SET_W+1];
            inv_d_all <= inv_bus[SET_W];
            inv_d_set <= inv_bus[SET_W-1:0];
            fd_v      <= fill_valid;
            fd_addr   <= fill_addr;
            fd_data   <= fill_data;
        end
    end

    assign fd_killed    = inv_d_stb && (inv_d_all || inv_d_set == fd_addr[OFF_W +: SET_W]);
    assign inv_hits_req = inv_d_stb && (inv_d_all || inv_d_set == req_addr[OFF_W +: SET_W]);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    hit_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    // R7 R8 R10
    inv_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && inv_hits_req) |=> !rsp_hit);

    // R4
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && fd_v && !fd_killed &&
         req_addr[ADDR_W-1:BYTE_W] == fd_addr[ADDR_W-1:BYTE_W])
        |=> (rsp_hit && rsp_rdata == $past(fd_data)));
endmodule

bind dc2_cache dc2_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WORDS(WORDS)
) u_chk (.*);

// File: tb/dc2_cache_bench.sv
`timescale 1ns/1ps
module dc2_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0, fill_data = '0;
    logic [7:0]  inv_bus = '0;
    logic        rsp_valid, rsp_hit, rsp_way;
    logic [31:0] rsp_rdata;

    always #4 clk = ~clk;

    dc2_cache u_dc2_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .inv_bus(inv_bus),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct packed {
        logic        hit;
        logic        way;
        logic [31:0] data;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    exp_t  cur;
    string cur_tag;
    int    checks = 0, fails = 0;
    bit    done = 0;

    logic        nx_fv = 1'b0;
    logic [31:0] nx_fa = '0, nx_fd = '0;
    logic [7:0]  nx_inv = '0;

    function automatic logic [31:0] mk(input int t, input int s, input int w);
        return {t[21:0], s[5:0], w[1:0], 2'b00};
    endfunction

    // Driver: one cycle of stimulus, expectation pushed for requests.
    task automatic cycle(input logic rv, input logic rw, input logic [31:0] ra,
                         input logic [31:0] wd, input logic eh, input logic ew,
                         input logic [31:0] ed, input string rq);
        req_valid = rv; req_write = rw; req_addr = ra; req_wdata = wd;
        fill_valid = nx_fv; fill_addr = nx_fa; fill_data = nx_fd;
        inv_bus = nx_inv;
        if (rv) begin
            exp_q.push_back('{hit: eh, way: ew, data: ed});
            tag_q.push_back(rq);
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; fill_valid = 1'b0; inv_bus = '0;
        nx_fv = 1'b0; nx_inv = '0;
    endtask

    task automatic rd(input logic [31:0] a, input logic eh, input logic ew,
                      input logic [31:0] ed, input string rq);
        cycle(1'b1, 1'b0, a, '0, eh, ew, eh ? ed : 32'h0, rq);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic eh,
                      input logic ew, input string rq);
        cycle(1'b1, 1'b1, a, d, eh, ew, 32'h0, rq);
    endtask

    task automatic idle();
        cycle(1'b0, 1'b0, '0, '0, 1'b0, 1'b0, '0, "");
    endtask

    task automatic fill(input logic [31:0] a, input logic [31:0] d);
        nx_fv = 1'b1; nx_fa = a; nx_fd = d;
        idle();
    endtask

    // Monitor: compare each response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected response hit=%0b data=%h expected none",
                         rsp_hit, rsp_rdata);
            end else begin
                cur = exp_q.pop_front();
                cur_tag = tag_q.pop_front();
                if (rsp_hit !== cur.hit || rsp_rdata !== cur.data ||
                    (cur.hit && rsp_way !== cur.way)) begin
                    fails++;
                    $display("FAIL %s: hit=%0b way=%0b data=%h expected hit=%0b way=%0b data=%h",
                             cur_tag, rsp_hit, rsp_way, rsp_rdata, cur.hit, cur.way, cur.data);
                end
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL R2: watchdog expired, actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset rsp_valid=%0b rsp_hit=%0b expected 0 0", rsp_valid, rsp_hit);
        end
        rst_n = 1'b1;
        @(negedge clk);

        rd(mk(1,3,0), 0, 0, 0, "R1");
        fill(mk(1,3,0), 32'hA000_0000);
        rd(mk(1,3,0), 1, 0, 32'hA000_0000, "R4");
        rd(mk(1,3,1), 0, 0, 0, "R3");
        rd(mk(2,3,0), 0, 0, 0, "R3");
        fill(mk(1,3,1), 32'hA000_0001);
        rd(mk(1,3,1), 1, 0, 32'hA000_0001, "R4");
        wr(mk(1,3,1), 32'h5EED_0001, 1, 0, "R5");
        rd(mk(1,3,1), 1, 0, 32'h5EED_0001, "R5");
        wr(mk(5,3,2), 32'hDEAD_0002, 0, 0, "R5");
        rd(mk(5,3,2), 0, 0, 0, "R5");

        fill(mk(2,3,0), 32'hB000_0000);
        fill(mk(2,3,1), 32'hB000_0001);
        rd(mk(2,3,0), 1, 1, 32'hB000_0000, "R6");
        rd(mk(1,3,0), 1, 0, 32'hA000_0000, "R6");
        fill(mk(3,3,0), 32'hC000_0000);
        rd(mk(3,3,0), 1, 1, 32'hC000_0000, "R6");
        rd(mk(2,3,0), 0, 0, 0, "R6");
        rd(mk(3,3,1), 0, 0, 0, "R12");
        rd(mk(1,3,1), 1, 0, 32'h5EED_0001, "R6");

        fill(mk(1,4,0), 32'hD000_0000);
        nx_inv = {2'b10, 6'd3};
        rd(mk(1,3,0), 1, 0, 32'hA000_0000, "R9");
        rd(mk(1,3,0), 0, 0, 0, "R7");
        rd(mk(3,3,0), 0, 0, 0, "R7");
        rd(mk(1,4,0), 1, 0, 32'hD000_0000, "R7");

        nx_inv = {2'b01, 6'd4};
        idle();
        rd(mk(1,4,0), 1, 0, 32'hD000_0000, "R11");

        nx_fv = 1'b1; nx_fa = mk(7,5,0); nx_fd = 32'hE000_0000;
        nx_inv = {2'b10, 6'd5};
        idle();
        rd(mk(7,5,0), 0, 0, 0, "R10");
        nx_fv = 1'b1; nx_fa = mk(7,6,0); nx_fd = 32'hE000_0001;
        nx_inv = {2'b10, 6'd5};
        idle();
        rd(mk(7,6,0), 1, 0, 32'hE000_0001, "R10");

        fill(mk(8,9,2), 32'hF000_0002);
        nx_inv = {2'b11, 6'd0};
        idle();
        rd(mk(1,4,0), 0, 0, 0, "R8");
        rd(mk(7,6,0), 0, 0, 0, "R8");
        rd(mk(8,9,2), 0, 0, 0, "R8");

        nx_fv = 1'b1; nx_fa = mk(9,10,0); nx_fd = 32'h6000_0000;
        rd(mk(9,10,0), 0, 0, 0, "R9");
        rd(mk(9,10,0), 1, 0, 32'h6000_0000, "R4");

        idle();
        idle();
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: %0d responses missing expected 0", exp_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule